// File: doc/BRIEF.md
# Floating-Point Register Stack Push

This block holds the eight 80-bit registers of a floating-point register stack and carries out load-style pushes onto it. The registers form a ring addressed through a 3-bit top pointer, so stack slot ST(i) lives in physical entry (top + i) mod 8. Each entry has a tag bit that records whether it is empty or holds a value. A push command either supplies an 80-bit value that was already converted from memory, or names a stack slot ST(i) whose contents are copied. The top pointer moves down by one, and the chosen value lands in the new ST(0).

The source slot is resolved against the top pointer as it stood before the push. A push of ST(0) therefore duplicates the current top. A push is refused in two cases: when the entry that would become the new ST(0) is still occupied (overflow), or when the named source slot is empty (underflow). A refused push raises a stack-fault status and leaves the stack, its tags and its top pointer exactly as they were. The overflow condition flag is set only for an overflow. A registered read port lets surrounding logic inspect any ST(i) together with its tag.

Top module: `fpstk_push`

## Requirements
- R1: An accepted push that does not fault changes the top pointer to (top - 1) mod 8. From top 0 it wraps to 7.
- R2: With cmd_src = 0 (memory source), an accepted push writes cmd_mem_val into the new ST(0) and marks that entry valid.
- R3: With cmd_src = 1 (register source), the value written is ST(cmd_idx), taken relative to the top pointer before the push. Pushing ST(0) duplicates the old top, so afterwards ST(0) and ST(1) are equal.
- R4: If the entry that would become the new ST(0) is already valid, the push overflows. c1_flag and stack_fault both read 1, and the top pointer, tags and register contents stay unchanged.
- R5: c1_flag reads 0 after any push that does not overflow, including a push that faults for underflow.
- R6: A register-source push whose source slot is empty is an underflow. stack_fault reads 1, c1_flag reads 0, and nothing in the stack changes.
- R7: rd_data and rd_tag give the contents and tag (1 = valid, 0 = empty) of ST(rd_idx) one clock after rd_idx is presented. Slot index i maps to physical entry (top + i) mod 8.
- R8: Synchronous reset sets the top pointer to 0, marks all eight tags empty, and clears c1_flag, stack_fault and push_done.
- R9: cmd_ready is 1 from the first clock after reset is released. push_done pulses for exactly one cycle after each accepted command. c1_flag and stack_fault hold the result of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Push command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_src | input | 1 | 0 = memory value, 1 = stack slot ST(cmd_idx) |
| cmd_idx | input | 3 | Source slot index for a register-source push |
| cmd_mem_val | input | 80 | Converted 80-bit value for a memory-source push |
| rd_idx | input | 3 | Slot index to inspect |
| rd_data | output | 80 | Contents of ST(rd_idx), one cycle later |
| rd_tag | output | 1 | Tag of ST(rd_idx), one cycle later |
| top_ptr | output | 3 | Current top-of-stack physical index |
| c1_flag | output | 1 | Overflow condition flag of the last push |
| stack_fault | output | 1 | Stack fault (overflow or underflow) of the last push |
| push_done | output | 1 | One-cycle pulse after an accepted command |

## Verification
The hardest situation to reach is overflow. It appears only after eight successful pushes have filled every entry, and then only while the top pointer sits on an entry that the wrap has brought back around. The stimulus first pushes mixed memory and register sources starting from top 0, so the first push wraps to entry 7. It then forces an underflow by naming a slot that has not yet been filled, and keeps pushing until all tags are set, so that the ninth push overflows. After each refused push, the stack is read back slot by slot to confirm that nothing moved.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int unsigned FPSTK_W     = 80;
  localparam int unsigned FPSTK_DEPTH = 8;

  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_REG = 1'b1
  } fpstk_src_e;
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter  int DEPTH = fpstk_pkg::FPSTK_DEPTH,
  parameter  int W     = fpstk_pkg::FPSTK_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    src_addr,
  output logic [W-1:0]     src_data,
  output logic             src_tag,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data,
  output logic             rd_tag,
  output logic [DEPTH-1:0] tags
);
  // Value storage: no reset, so it can map onto distributed RAM.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tags   <= '0;
      rd_tag <= 1'b0;
    end else begin
      if (we) tags[waddr] <= 1'b1;
      rd_tag <= tags[rd_addr];
    end
  end

  assign src_data = mem[src_addr];
  assign src_tag  = tags[src_addr];

  // R2: a write leaves the target entry marked valid
  p_tag_set_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> tags[$past(waddr)]);

  // R8: reset empties every entry
  p_reset_empty_r8: assert property (@(posedge clk)
    rst |=> (tags == '0) && !rd_tag);
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl #(
  parameter  int DEPTH = fpstk_pkg::FPSTK_DEPTH,
  parameter  int W     = fpstk_pkg::FPSTK_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_src,
  input  logic [AW-1:0]    cmd_idx,
  input  logic [W-1:0]     cmd_mem_val,
  input  logic [W-1:0]     src_data,
  input  logic             src_tag,
  input  logic [DEPTH-1:0] tags,
  output logic             cmd_ready,
  output logic [AW-1:0]    top,
  output logic [AW-1:0]    src_addr,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [W-1:0]     wdata,
  output logic             c1,
  output logic             fault,
  output logic             done
);
  import fpstk_pkg::*;

  fpstk_src_e   src_kind;
  logic         accept;
  logic [AW-1:0] next_top;
  logic         overflow;
  logic         underflow;
  logic         refuse;

  assign src_kind  = fpstk_src_e'(cmd_src);
  assign accept    = cmd_valid && cmd_ready;
  assign next_top  = top - AW'(1);
  // Source slot is resolved against the pointer before it moves.
  assign src_addr  = top + cmd_idx;
  assign overflow  = tags[next_top];
  assign underflow = (src_kind == SRC_REG) && !src_tag;
  assign refuse    = overflow || underflow;

  assign we    = accept && !refuse;
  assign waddr = next_top;
  assign wdata = (src_kind == SRC_REG) ? src_data : cmd_mem_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b0;
      top       <= '0;
      c1        <= 1'b0;
      fault     <= 1'b0;
      done      <= 1'b0;
    end else begin
      cmd_ready <= 1'b1;
      done      <= accept;
      if (accept) begin
        c1    <= overflow;
        fault <= refuse;
        if (!refuse) top <= next_top;
      end
    end
  end

  // R1: a clean push moves the pointer down by one
  p_top_dec_r1: assert property (@(posedge clk) disable iff (rst)
    (accept && !refuse) |=> (top == $past(top) - AW'(1)));

  // R4: a refused push keeps the pointer
  p_top_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && refuse) |=> (top == $past(top)));

  // R9: completion pulse lasts one cycle unless another command follows
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(accept, 2)) |-> $past(accept));
endmodule

// File: rtl/fpstk_push.sv
module fpstk_push #(
  parameter  int DEPTH = fpstk_pkg::FPSTK_DEPTH,
  parameter  int W     = fpstk_pkg::FPSTK_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_src,
  input  logic [AW-1:0] cmd_idx,
  input  logic [W-1:0]  cmd_mem_val,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          rd_tag,
  output logic [AW-1:0] top_ptr,
  output logic          c1_flag,
  output logic          stack_fault,
  output logic          push_done
);
  logic [AW-1:0]    top;
  logic [AW-1:0]    src_addr;
  logic [W-1:0]     src_data;
  logic             src_tag;
  logic [DEPTH-1:0] tags;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [W-1:0]     wdata;
  logic [AW-1:0]    rd_phys;

  assign rd_phys = top + rd_idx;
  assign top_ptr = top;

  fpstk_regfile #(.DEPTH(DEPTH), .W(W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .src_addr (src_addr),
    .src_data (src_data),
    .src_tag  (src_tag),
    .rd_addr  (rd_phys),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .tags     (tags)
  );

  fpstk_ctrl #(.DEPTH(DEPTH), .W(W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_src     (cmd_src),
    .cmd_idx     (cmd_idx),
    .cmd_mem_val (cmd_mem_val),
    .src_data    (src_data),
    .src_tag     (src_tag),
    .tags        (tags),
    .cmd_ready   (cmd_ready),
    .top         (top),
    .src_addr    (src_addr),
    .we          (we),
    .waddr       (waddr),
    .wdata       (wdata),
    .c1          (c1_flag),
    .fault       (stack_fault),
    .done        (push_done)
  );

  // R5: the overflow flag never appears without a stack fault
  p_c1_implies_fault_r5: assert property (@(posedge clk) disable iff (rst)
    c1_flag |-> stack_fault);

  // R6: a refused push leaves every tag as it was
  p_fault_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (push_done && stack_fault) |-> $stable(tags));

  // R4: overflow is only reported when the whole stack was occupied
  p_ovf_full_r4: assert property (@(posedge clk) disable iff (rst)
    (push_done && c1_flag) |-> (tags == '1));
endmodule

// File: tb/fpstk_push_tb_top.sv
`timescale 1ns/1ps
module fpstk_push_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_src = 1'b0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_mem_val = '0;
  logic [2:0]  rd_idx = '0;
  logic [79:0] rd_data;
  logic        rd_tag;
  logic [2:0]  top_ptr;
  logic        c1_flag;
  logic        stack_fault;
  logic        push_done;

  int checks = 0;
  int fails  = 0;

  logic [79:0] m_val [8];
  bit          m_tag [8];
  int          m_top;

  always #10 clk = ~clk;

  fpstk_push dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_idx(cmd_idx), .cmd_mem_val(cmd_mem_val),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag), .top_ptr(top_ptr),
    .c1_flag(c1_flag), .stack_fault(stack_fault), .push_done(push_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 8; k++) m_tag[k] = 0;
    m_top = 0;
  endtask

  // Push through the ports and compare against the model.
  task automatic do_push(input bit is_reg, input int idx,
                         input logic [79:0] v, input string req);
    int nt, sp;
    bit ov, uf;
    logic [79:0] val;
    nt  = (m_top + 7) % 8;
    sp  = (m_top + idx) % 8;
    ov  = m_tag[nt];
    uf  = is_reg && !m_tag[sp];
    val = is_reg ? m_val[sp] : v;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src = is_reg; cmd_idx = 3'(idx); cmd_mem_val = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9", "push_done", 80'(push_done), 80'd1);
    chk(req, "c1_flag", 80'(c1_flag), 80'(ov));
    chk(req, "stack_fault", 80'(stack_fault), 80'(ov | uf));
    if (!(ov || uf)) begin
      m_val[nt] = val; m_tag[nt] = 1; m_top = nt;
    end
    chk(req, "top_ptr", 80'(top_ptr), 80'(m_top));
    @(negedge clk);
    chk("R9", "push_done low", 80'(push_done), 80'd0);
  endtask

  task automatic read_st(input int i, input string req);
    int ph;
    ph = (m_top + i) % 8;
    @(negedge clk);
    rd_idx = 3'(i);
    @(negedge clk);
    chk(req, $sformatf("tag ST(%0d)", i), 80'(rd_tag), 80'(m_tag[ph]));
    if (m_tag[ph]) chk(req, $sformatf("data ST(%0d)", i), rd_data, m_val[ph]);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) read_st(i, req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R8", "top after reset", 80'(top_ptr), 80'd0);
    chk("R8", "c1 after reset", 80'(c1_flag), 80'd0);
    chk("R8", "fault after reset", 80'(stack_fault), 80'd0);
    chk("R9", "ready", 80'(cmd_ready), 80'd1);
    read_all("R8");
  endtask

  task automatic t_mem_push();
    do_push(1'b0, 0, 80'h3FFF_8000_0000_0000_0000, "R1");
    chk("R1", "wrap to 7", 80'(top_ptr), 80'd7);
    do_push(1'b0, 0, 80'hC000_C000_0000_0000_1234, "R2");
    chk("R5", "c1 clean push", 80'(c1_flag), 80'd0);
    read_all("R2");
  endtask

  task automatic t_dup_top();
    do_push(1'b1, 0, 80'hDEAD, "R3");
    read_st(0, "R3");
    read_st(1, "R3");
    chk("R3", "dup equal", m_val[m_top], m_val[(m_top + 1) % 8]);
  endtask

  task automatic t_reg_deep();
    do_push(1'b1, 2, 80'hBEEF, "R3");
    read_all("R7");
  endtask

  task automatic t_underflow();
    do_push(1'b1, 5, 80'h1, "R6");
    chk("R6", "fault", 80'(stack_fault), 80'd1);
    chk("R5", "c1 on underflow", 80'(c1_flag), 80'd0);
    read_all("R6");
  endtask

  task automatic t_fill_overflow();
    for (int k = 0; k < 4; k++)
      do_push(1'b0, 0, 80'h4000_A000_0000_0000_0000 + 80'(k), "R2");
    chk("R1", "top at 0", 80'(top_ptr), 80'd0);
    do_push(1'b0, 0, 80'h7FFF_C000_0000_0000_0000, "R4");
    chk("R4", "c1 on overflow", 80'(c1_flag), 80'd1);
    chk("R4", "fault on overflow", 80'(stack_fault), 80'd1);
    read_all("R4");
  endtask

  task automatic t_wrap_read();
    read_st(7, "R7");
    chk("R7", "ST7 is first push", rd_data, 80'h3FFF_8000_0000_0000_0000);
  endtask

  initial begin
    t_reset();
    t_mem_push();
    t_dup_top();
    t_reg_deep();
    t_underflow();
    t_fill_overflow();
    t_wrap_read();
    t_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule